// File: doc/BRIEF.md
# Plug-and-Play Initiation Key Detector

This block watches byte writes to the card's auto-configuration address port and reports when the 32-byte unlock sequence has been written, one byte after another, with no wrong byte in between. Each written byte is compared against an expected byte. The expected bytes are not held in a table. An 8-bit feedback shift register produces them, starting from 6Ah.

A matching byte advances the shift register and a position counter. A wrong byte restarts the search. If that wrong byte is itself 6Ah, it is taken as the first byte of a new attempt. When the last byte matches, the block raises a single-cycle detection pulse, and the card logic uses it to leave its locked state.

The detector is active only while its enable input is high, which the card holds during its locked state. Dropping the enable discards any partial progress.

Top module: `pnp_key_detect`

## Requirements
- R1: After the synchronous active-high reset, `key_hit_o` is 0 and the match position is at the first key byte, so a complete key written right away is detected.
- R2: The expected key byte 0 is 6Ah. Each following byte is the previous byte shifted right by one, with bit 7 set to the XOR of the previous byte's bits 0 and 1. This gives 32 bytes in total, starting 6A, B5, DA, ED and ending 73, 39.
- R3: When the 32nd consecutive matching byte is written, `key_hit_o` is 1 for exactly one cycle, in the cycle after that write. An incomplete or corrupted key never raises it.
- R4: A clock cycle with `addr_wr_i` low has no effect on progress, whatever `addr_data_i` holds. Idle cycles may therefore separate the key bytes.
- R5: A written byte that does not match restarts the search. If that byte is 6Ah, it counts as the first matched byte, and the next expected byte is B5h.
- R6: While `en_i` is low, writes are ignored, `key_hit_o` stays 0, and any partial progress is cleared.
- R7: After a detection, matching starts again from byte 0, so only a further complete key produces another pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | High while the card waits for the key |
| addr_wr_i | input | 1 | Address-port write strobe, one byte per cycle |
| addr_data_i | input | 8 | Byte written to the address port |
| key_hit_o | output | 1 | One-cycle pulse when the full key has been seen |

## Verification
The bench targets a wrong byte of 6Ah in the middle of a key. A design that does not treat it as a fresh start misses the key that follows. It also writes a key that breaks off after 31 bytes and a key with one corrupted byte in the middle. A design with an off-by-one count or a loose comparison would pulse on either of these. The bench drops the enable halfway through a key and then sends the remaining bytes with the enable high again. A design that keeps stale progress would fire here. It also sends two keys back to back, which catches a design that fails to rewind after a hit. Idle cycles carrying junk data expose a design that samples the data bus without the strobe.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

    localparam int          KEY_BYTES = 32;
    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  KEY_SEED  = 8'h6A;

    typedef logic [BYTE_W-1:0] key_byte_t;

    // Action applied to generator and position counter each cycle
    typedef enum logic [1:0] {
        STEP_HOLD      = 2'd0,  // no write this cycle
        STEP_ADVANCE   = 2'd1,  // byte matched, move on
        STEP_REWIND    = 2'd2,  // back to byte 0
        STEP_REWIND_1  = 2'd3   // mismatch on seed byte: count it as byte 0
    } step_e;

    typedef struct packed {
        logic      stb;
        logic      match;
        logic      seed_hit;
        logic      last;
    } cmp_t;

    function automatic key_byte_t key_next(input key_byte_t cur);
        key_byte_t nxt;
        nxt = cur >> 1;
        nxt[BYTE_W-1] = cur[0] ^ cur[1];
        return nxt;
    endfunction

endpackage

// File: rtl/pnp_key_gen.sv
module pnp_key_gen
    import pnp_key_pkg::*;
#(
    parameter key_byte_t SEED = KEY_SEED
) (
    input  logic      clk,
    input  logic      rst,
    input  step_e     step_i,
    output key_byte_t exp_o
);

    key_byte_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            unique case (step_i)
                STEP_HOLD:     state_q <= state_q;
                STEP_ADVANCE:  state_q <= key_next(state_q);
                STEP_REWIND:   state_q <= SEED;
                STEP_REWIND_1: state_q <= key_next(SEED);
                default:       state_q <= SEED;
            endcase
        end
    end

    assign exp_o = state_q;

    // R5
    rewind_one_chk: assert property (@(posedge clk) disable iff (rst)
        step_i == STEP_REWIND_1 |=> exp_o == key_next(SEED));

    // R4
    hold_gen_chk: assert property (@(posedge clk) disable iff (rst)
        step_i == STEP_HOLD |=> $stable(exp_o));

endmodule

// File: rtl/pnp_key_count.sv
module pnp_key_count
    import pnp_key_pkg::*;
#(
    parameter int KEY_LEN = KEY_BYTES,
    localparam int IDX_W  = $clog2(KEY_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else begin
            unique case (step_i)
                STEP_HOLD:     idx_q <= idx_q;
                STEP_ADVANCE:  idx_q <= idx_q + 1'b1;
                STEP_REWIND:   idx_q <= '0;
                STEP_REWIND_1: idx_q <= IDX_W'(1);
                default:       idx_q <= '0;
            endcase
        end
    end

    assign idx_o = idx_q;

    // R5
    mismatch_restart_chk: assert property (@(posedge clk) disable iff (rst)
        step_i == STEP_REWIND |=> idx_o == '0);

    // R4
    hold_idx_chk: assert property (@(posedge clk) disable iff (rst)
        step_i == STEP_HOLD |=> $stable(idx_o));

endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect
    import pnp_key_pkg::*;
#(
    parameter int        KEY_LEN = KEY_BYTES,
    parameter key_byte_t SEED    = KEY_SEED,
    localparam int       IDX_W   = $clog2(KEY_LEN)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  logic        addr_wr_i,
    input  logic [7:0]  addr_data_i,
    output logic        key_hit_o
);

    key_byte_t        exp_byte;
    logic [IDX_W-1:0] idx;
    cmp_t             cmp;
    step_e            step;
    logic             hit_q;

    pnp_key_gen #(.SEED(SEED)) gen_i (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .exp_o  (exp_byte)
    );

    pnp_key_count #(.KEY_LEN(KEY_LEN)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .idx_o  (idx)
    );

    always_comb begin
        cmp.stb      = en_i && addr_wr_i;
        cmp.match    = cmp.stb && (addr_data_i == exp_byte);
        cmp.seed_hit = cmp.stb && !cmp.match && (addr_data_i == SEED);
        cmp.last     = cmp.match && (idx == IDX_W'(KEY_LEN - 1));
    end

    always_comb begin
        if (!en_i)             step = STEP_REWIND;
        else if (!cmp.stb)     step = STEP_HOLD;
        else if (cmp.last)     step = STEP_REWIND;
        else if (cmp.match)    step = STEP_ADVANCE;
        else if (cmp.seed_hit) step = STEP_REWIND_1;
        else                   step = STEP_REWIND;
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= cmp.last;
    end

    assign key_hit_o = hit_q;

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        key_hit_o |=> !key_hit_o);

    // R3
    pulse_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        key_hit_o |-> $past(en_i && addr_wr_i));

    // R6
    disabled_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (idx == '0) && !key_hit_o);

    // R2
    start_seed_chk: assert property (@(posedge clk) disable iff (rst)
        idx == '0 |-> exp_byte == SEED);

    // R7
    rewind_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
        key_hit_o |-> idx == '0);

endmodule

// File: tb/pnp_key_detect_tb_top.sv
module pnp_key_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic       addr_wr_i = 1'b0;
    logic [7:0] addr_data_i = 8'h00;
    logic       key_hit_o;

    always #2 clk = ~clk;

    pnp_key_detect dut_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .addr_wr_i   (addr_wr_i),
        .addr_data_i (addr_data_i),
        .key_hit_o   (key_hit_o)
    );

    typedef struct {
        bit    hit;
        string req;
    } exp_item_t;

    exp_item_t  sb_q[$];
    logic [7:0] key[32];
    int         pos = 0;
    int         checks = 0;
    int         failures = 0;
    bit         done = 0;

    task automatic check(input bit got, input bit want, input string req);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s key_hit_o actual=%0b expected=%0b", req, got, want);
        end
    endtask

    // driver: one cycle of stimulus, reference model pushes expectation
    task automatic drive(input bit en, input bit wr, input logic [7:0] b, input string req);
        exp_item_t it;
        @(negedge clk);
        en_i = en; addr_wr_i = wr; addr_data_i = b;
        it.hit = 0;
        if (!en) pos = 0;
        else if (wr) begin
            if (b == key[pos]) begin
                pos++;
                if (pos == 32) begin it.hit = 1; pos = 0; end
            end else pos = (b == key[0]) ? 1 : 0;
        end
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic send_range(input int lo, input int hi, input bit en, input string req);
        for (int i = lo; i <= hi; i++) drive(en, 1'b1, key[i], req);
    endtask

    // monitor
    initial begin
        exp_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(key_hit_o, it.hit, it.req);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        key[0] = 8'h6A;
        for (int i = 1; i < 32; i++)
            key[i] = {key[i-1][1] ^ key[i-1][0], key[i-1][7:1]};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(key_hit_o, 1'b0, "R1");
        rst = 1'b0;

        // R1/R2/R3: full key straight after reset
        send_range(0, 31, 1'b1, "R2");
        drive(1'b1, 1'b0, 8'h00, "R3");
        drive(1'b1, 1'b0, 8'h00, "R3");

        // R4: idle cycles with junk data between key bytes
        for (int i = 0; i < 32; i++) begin
            drive(1'b1, 1'b1, key[i], "R4");
            drive(1'b1, 1'b0, key[0], "R4");
            drive(1'b1, 1'b0, 8'hFF, "R4");
        end

        // R3: only 31 bytes, then a wrong byte
        send_range(0, 30, 1'b1, "R3");
        drive(1'b1, 1'b1, 8'h00, "R3");
        // R3: corrupted middle byte then the rest
        send_range(0, 16, 1'b1, "R3");
        drive(1'b1, 1'b1, key[17] ^ 8'h04, "R3");
        send_range(18, 31, 1'b1, "R3");

        // R5: wrong byte restarts; full key afterwards detected
        send_range(0, 9, 1'b1, "R5");
        drive(1'b1, 1'b1, 8'h13, "R5");
        send_range(0, 31, 1'b1, "R5");
        // R5: seed byte as mismatch counts as byte 0
        send_range(0, 11, 1'b1, "R5");
        drive(1'b1, 1'b1, 8'h6A, "R5");
        send_range(1, 31, 1'b1, "R5");

        // R6: enable drop clears progress
        send_range(0, 15, 1'b1, "R6");
        drive(1'b0, 1'b0, 8'h00, "R6");
        send_range(16, 31, 1'b1, "R6");
        // R6: whole key with enable low
        send_range(0, 31, 1'b0, "R6");
        drive(1'b1, 1'b0, 8'h00, "R6");

        // R7: back-to-back keys, then tail only
        send_range(0, 31, 1'b1, "R7");
        send_range(0, 31, 1'b1, "R7");
        send_range(1, 31, 1'b1, "R7");
        drive(1'b1, 1'b0, 8'h00, "R7");

        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule